// File: doc/BRIEF.md
# Sign-Sign LMS Coefficient Counter

This block holds one adaptive correction coefficient that is trained by a sign-sign least-mean-squares rule. Each sample it receives two comparator decisions, the sign of a residual gradient error and the sign of a reference average. It also receives an update strobe. When an update is applied, the coefficient moves by one count. It steps up when the two signs agree and down when they differ. The coefficient is a 12-bit two's-complement value and it clamps at both ends of its range instead of wrapping.

The learning rate is set by how often updates are applied, not by the step size. A divider, set by a 3-bit rate input, passes only every 2^k-th strobe through to the counter. Two outputs leave the block. The first is the bitwise complement of the coefficient, for the opposite leg of a differential circuit. The second is a pair of 15-line thermometer buses, decoded from the upper eight coefficient bits, for a segmented capacitor DAC. Coarse columns come from bits [11:8] and fine units from bits [7:4]. The lowest four bits add resolution that the DAC never sees.

Top module: `sslms_coef_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the coefficient to 0, the complement to 4095, both thermometer buses to all zeros and the strobe divider count to zero.
- R2: A sign input of 1 means positive and 0 means negative. An applied update with equal signs raises the coefficient by exactly 1, and the new value shows on the rising edge that samples the strobe.
- R3: An applied update with unequal signs lowers the coefficient by exactly 1, on that same edge.
- R4: `coef_neg` always equals 4095 minus `coef_pos` (the bitwise inverse of the 12 bits).
- R5: The coefficient saturates. Upward updates at +2047 (0x7FF) leave it at +2047, and downward updates at -2048 (0x800) leave it at -2048.
- R6: With rate input k, only every 2^k-th strobe counted since reset is applied. Other strobes, and cycles with the strobe low, leave the coefficient unchanged.
- R7: Take coefficient bits [11:8] as an unsigned number N. `coarse_therm` then has lines 0 to N-1 high and all other lines low.
- R8: Take coefficient bits [7:4] as an unsigned number M. `fine_therm` then has lines 0 to M-1 high and all other lines low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_strobe | input | 1 | Update request for this sample |
| err_sign | input | 1 | Sign of gradient error, 1 = positive |
| ref_sign | input | 1 | Sign of average signal, 1 = positive |
| rate_sel | input | 3 | Divider exponent k; applies every 2^k-th strobe |
| coef_pos | output | 12 | Coefficient, two's complement |
| coef_neg | output | 12 | Complementary coefficient, 4095 - coef_pos |
| coarse_therm | output | 15 | Thermometer code of bits [11:8] |
| fine_therm | output | 15 | Thermometer code of bits [7:4] |

## Verification
The only register between the strobe and the results is the coefficient register, so an applied update appears one rising edge after the strobe is sampled. The complement and both thermometer buses follow from the coefficient combinationally in that same cycle. The bench drives inputs on the falling edge and samples every output on the next falling edge, one half period after the edge that loads the register. For the divider tests, the bench counts strobes from a fresh reset so that the expected firing strobe is known exactly.

// File: rtl/sslms_pkg.sv
package sslms_pkg;

    localparam int COEF_W_DEF = 12;
    localparam int DAC_W_DEF  = 8;
    localparam int SEG_W_DEF  = 4;
    localparam int RATE_W_DEF = 3;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } step_dir_e;

    typedef struct packed {
        logic      apply;
        step_dir_e dir;
    } upd_cmd_t;

    // product of two sign bits (1 = positive): agree -> up
    function automatic step_dir_e sign_product(logic s_a, logic s_b);
        return (s_a ~^ s_b) ? DIR_UP : DIR_DOWN;
    endfunction

endpackage

// File: rtl/sslms_rate_div.sv
module sslms_rate_div #(
    parameter int RATE_W = sslms_pkg::RATE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              fire
);
    localparam int CNT_W = (2 ** RATE_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;

    assign mask = ~({CNT_W{1'b1}} << rate_sel);
    assign fire = strobe && ((cnt_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (strobe)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    // R6: no applied update without a strobe
    p_fire_needs_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        fire |-> strobe);
    // R6: divide-by-one passes every strobe
    p_div1_passes_r6: assert property (@(posedge clk) disable iff (rst)
        (strobe && rate_sel == '0) |-> fire);

endmodule

// File: rtl/sslms_coef_cnt.sv
module sslms_coef_cnt
    import sslms_pkg::*;
#(
    parameter int COEF_W = COEF_W_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  upd_cmd_t                 cmd,
    output logic signed [COEF_W-1:0] coef
);
    localparam logic signed [COEF_W-1:0] C_MAX = {1'b0, {(COEF_W-1){1'b1}}};
    localparam logic signed [COEF_W-1:0] C_MIN = {1'b1, {(COEF_W-1){1'b0}}};

    logic signed [COEF_W-1:0] coef_q, coef_d;

    always_comb begin
        coef_d = coef_q;
        if (cmd.apply) begin
            if (cmd.dir == DIR_UP && coef_q != C_MAX)
                coef_d = coef_q + COEF_W'(1);
            else if (cmd.dir == DIR_DOWN && coef_q != C_MIN)
                coef_d = coef_q - COEF_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) coef_q <= '0;
        else     coef_q <= coef_d;
    end

    assign coef = coef_q;

    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> coef_q == '0);
    p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd.apply && cmd.dir == DIR_UP && coef_q != C_MAX) |=> coef_q == $past(coef_q) + COEF_W'(1));
    p_step_down_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd.apply && cmd.dir == DIR_DOWN && coef_q != C_MIN) |=> coef_q == $past(coef_q) - COEF_W'(1));
    p_sat_high_r5: assert property (@(posedge clk) disable iff (rst)
        (coef_q == C_MAX && cmd.dir == DIR_UP) |=> coef_q == C_MAX);
    p_sat_low_r5: assert property (@(posedge clk) disable iff (rst)
        (coef_q == C_MIN && cmd.dir == DIR_DOWN) |=> coef_q == C_MIN);
    p_hold_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !cmd.apply |=> $stable(coef_q));

endmodule

// File: rtl/sslms_therm.sv
module sslms_therm #(
    parameter int SEG_W = sslms_pkg::SEG_W_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SEG_W-1:0]         code,
    output logic [(2**SEG_W)-2:0]    lines
);
    localparam int LINES = (2 ** SEG_W) - 1;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign lines[i] = (code > SEG_W'(i));
    end

    // R7/R8: number of active lines matches the code
    p_therm_count_r7: assert property (@(posedge clk) disable iff (rst)
        $countones(lines) == int'(code));
    // R8: lines form a contiguous run from line 0
    p_therm_contig_r8: assert property (@(posedge clk) disable iff (rst)
        ((lines & (lines + LINES'(1))) == '0));

endmodule

// File: rtl/sslms_coef_ctrl.sv
module sslms_coef_ctrl
    import sslms_pkg::*;
#(
    parameter int COEF_W = COEF_W_DEF,
    parameter int DAC_W  = DAC_W_DEF,
    parameter int SEG_W  = SEG_W_DEF,
    parameter int RATE_W = RATE_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  upd_strobe,
    input  logic                  err_sign,
    input  logic                  ref_sign,
    input  logic [RATE_W-1:0]     rate_sel,
    output logic [COEF_W-1:0]     coef_pos,
    output logic [COEF_W-1:0]     coef_neg,
    output logic [(2**SEG_W)-2:0] coarse_therm,
    output logic [(2**SEG_W)-2:0] fine_therm
);
    localparam int NSEG  = DAC_W / SEG_W;
    localparam int LINES = (2 ** SEG_W) - 1;

    logic                     fire;
    upd_cmd_t                 cmd;
    logic signed [COEF_W-1:0] coef;
    logic [LINES-1:0]         seg_lines [NSEG];

    sslms_rate_div #(.RATE_W(RATE_W)) u_div (
        .clk(clk), .rst(rst), .strobe(upd_strobe),
        .rate_sel(rate_sel), .fire(fire)
    );

    assign cmd.apply = fire;
    assign cmd.dir   = sign_product(err_sign, ref_sign);

    sslms_coef_cnt #(.COEF_W(COEF_W)) u_cnt (
        .clk(clk), .rst(rst), .cmd(cmd), .coef(coef)
    );

    assign coef_pos = coef;
    assign coef_neg = ~coef;

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        sslms_therm #(.SEG_W(SEG_W)) u_therm (
            .clk(clk), .rst(rst),
            .code(coef[COEF_W-1-s*SEG_W -: SEG_W]),
            .lines(seg_lines[s])
        );
    end

    assign coarse_therm = seg_lines[0];
    assign fine_therm   = seg_lines[NSEG-1];

    // R4: the two legs always sum to all ones
    p_complement_sum_r4: assert property (@(posedge clk) disable iff (rst)
        (coef_pos + coef_neg) == {COEF_W{1'b1}});

endmodule

// File: tb/tb_sslms_coef_ctrl.sv
module tb_sslms_coef_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        upd_strobe, err_sign, ref_sign;
    logic [2:0]  rate_sel;
    logic [11:0] coef_pos, coef_neg;
    logic [14:0] coarse_therm, fine_therm;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    sslms_coef_ctrl dut (
        .clk(clk), .rst(rst), .upd_strobe(upd_strobe),
        .err_sign(err_sign), .ref_sign(ref_sign), .rate_sel(rate_sel),
        .coef_pos(coef_pos), .coef_neg(coef_neg),
        .coarse_therm(coarse_therm), .fine_therm(fine_therm)
    );

    // vector: {strobe, err_sign, ref_sign, expected coefficient}
    localparam int NVEC = 12;
    localparam logic [14:0] VEC [NVEC] = '{
        {3'b111, 12'h001}, {3'b111, 12'h002}, {3'b100, 12'h003},
        {3'b110, 12'h002}, {3'b101, 12'h001}, {3'b011, 12'h001},
        {3'b101, 12'h000}, {3'b100, 12'h001}, {3'b110, 12'h000},
        {3'b101, 12'hFFF}, {3'b110, 12'hFFE}, {3'b000, 12'hFFE}
    };

    function automatic logic [14:0] ref_therm(int n);
        logic [14:0] t = '0;
        for (int i = 0; i < 15; i++) if (i < n) t[i] = 1'b1;
        return t;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_all(string req, logic [11:0] e);
        chk({req, " coef"}, int'(coef_pos), int'(e));
        chk("R4 complement", int'(coef_neg), 4095 - int'(e));
        chk("R7 coarse", int'(coarse_therm), int'(ref_therm(int'(e[11:8]))));
        chk("R8 fine", int'(fine_therm), int'(ref_therm(int'(e[7:4]))));
    endtask

    task automatic one_strobe(logic g, logic a);
        @(negedge clk);
        upd_strobe = 1'b1; err_sign = g; ref_sign = a;
        @(negedge clk);
        upd_strobe = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=done", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; upd_strobe = 1'b0; err_sign = 1'b0; ref_sign = 1'b0; rate_sel = 3'd0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk_all("R1 reset", 12'h000);

        // R2/R3 table walk, k = 0
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            upd_strobe = VEC[v][14]; err_sign = VEC[v][13]; ref_sign = VEC[v][12];
            @(negedge clk);
            upd_strobe = 1'b0;
            chk_all(VEC[v][13] ~^ VEC[v][12] ? "R2 table" : "R3 table", VEC[v][11:0]);
        end

        // R1 reset from non-zero state
        do_reset();
        chk_all("R1 reset mid-run", 12'h000);

        // R5 saturation high
        @(negedge clk);
        upd_strobe = 1'b1; err_sign = 1'b0; ref_sign = 1'b0;
        repeat (2060) @(negedge clk);
        chk_all("R5 sat high", 12'h7FF);
        // R5 saturation low
        err_sign = 1'b1;
        repeat (4110) @(negedge clk);
        upd_strobe = 1'b0;
        chk_all("R5 sat low", 12'h800);
        one_strobe(1'b0, 1'b0);
        chk_all("R5 leave low", 12'h801);

        // R6 divider k = 2
        do_reset();
        rate_sel = 3'd2;
        for (int s = 1; s <= 3; s++) begin
            one_strobe(1'b1, 1'b1);
            chk_all("R6 k2 skipped", 12'h000);
        end
        repeat (3) @(negedge clk);
        chk_all("R6 idle hold", 12'h000);
        one_strobe(1'b1, 1'b1);
        chk_all("R6 k2 fourth", 12'h001);

        // R6 divider k = 3
        do_reset();
        rate_sel = 3'd3;
        for (int s = 1; s <= 7; s++) one_strobe(1'b0, 1'b1);
        chk_all("R6 k3 skipped", 12'h000);
        one_strobe(1'b0, 1'b1);
        chk_all("R6 k3 eighth", 12'hFFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule